// File: doc/BRIEF.md
# Dual-Channel Command Decode Register Bank

This block sits behind a serial word receiver in a two-channel voltage-output converter. Each completed 16-bit command word arrives with a one-cycle load strobe. The bank decodes the word's control field and then writes one or more of its registers. Each channel has an input (staging) register, an output register that holds the active code, and a power-down mode. The block drives the active 12-bit code and the 2-bit power-down mode of both channels to the analog side.

The staging register lets software preload one channel and later move both channels to their outputs in a single command. The output register can also be written directly, or both channels can be loaded at once. A power-down command changes only the mode of the addressed channel or channels. The codes already held stay untouched, so normal operation resumes at the previous level.

An active-low asynchronous clear returns every register to the power-on state at once, with zero-scale codes and normal mode. After the clear is released, no command takes effect until the receiver reports a frame edge (the end-of-frame sync rising edge). This stops a word whose frame was cut by the clear from landing on the outputs.

Top module: `dac_cmd_bank`

## Requirements
- R1: While `rst_ni` is low, and after it is released before any command applies, both codes read 0 and both power-down modes read 00.
- R2: Word layout: bits 15:14 are the load select, bit 13 picks the channel (0 = A, 1 = B), bit 12 picks power-down (1) or data (0), and bits 11:0 are a straight-binary code (0 = zero scale, all ones = full scale minus one LSB).
- R3: A data word with load select 00 writes only the addressed channel's input register. Neither output changes.
- R4: A data word with load select 01 writes the addressed channel's output code directly. The other channel and both input registers are left unchanged.
- R5: A data word with load select 10 writes the addressed channel's input register, then copies both input registers (including the new value) to their output codes.
- R6: A data word with load select 11 writes the code into the input and output registers of both channels, whatever bit 13 holds.
- R7: A power-down word sets the mode from bits 11:10 (00 normal, 01 1 kΩ to ground, 10 100 kΩ to ground, 11 high impedance). It applies to the addressed channel, or to both channels when the load select is 11. All codes and input registers are kept.
- R8: Outputs change only in the cycle after an applied strobe. A channel that the word does not address keeps its state.
- R9: After the clear is released, strobes are discarded until `frame_edge_i` has been seen. A strobe that arrives in the same cycle as that first frame edge is applied.
- R10: Pulling `rst_ni` low resets all outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous clear |
| strobe_i | input | 1 | One-cycle pulse: `word_i` is a complete command |
| frame_edge_i | input | 1 | One-cycle pulse: end-of-frame sync edge |
| word_i | input | 16 | Command word |
| code_a_o | output | 12 | Channel A active code |
| code_b_o | output | 12 | Channel B active code |
| pd_a_o | output | 2 | Channel A power-down mode |
| pd_b_o | output | 2 | Channel B power-down mode |

## Verification
Assertions run on every cycle and check that the outputs hold when no command is applied, that direct and broadcast data writes land in the next cycle, and that power-down words update only the mode. The contents of the staging registers cannot be seen at the ports. So the rules that a direct write spares them (R4) and that a transfer copies them (R5) are shown only by the bench's command sequences. The same holds for the immediate effect of the asynchronous clear and for the discarding of strobes until a frame edge has been seen after release.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    LD_IN   = 2'b00,
    LD_OUT  = 2'b01,
    LD_XFER = 2'b10,
    LD_ALL  = 2'b11
  } ld_sel_e;

  typedef enum logic [1:0] {
    PD_OFF   = 2'b00,
    PD_R1K   = 2'b01,
    PD_R100K = 2'b10,
    PD_HIZ   = 2'b11
  } pd_mode_e;

  typedef struct packed {
    logic in_we;
    logic out_we;
    logic xfer;
    logic pd_we;
  } ch_ctl_t;
endpackage

// File: rtl/dac_clr_gate.sv
module dac_clr_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic frame_edge_i,
  output logic apply_o
);
  logic armed_q;

  // armed once a frame edge is seen after clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           armed_q <= 1'b0;
    else if (frame_edge_i) armed_q <= 1'b1;
  end

  assign apply_o = strobe_i && (armed_q || frame_edge_i);
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                               apply_i,
  input  logic [DATA_W+3:0]                  word_i,
  output ch_ctl_t [NUM_CH-1:0]               ctl_o,
  output logic [DATA_W-1:0]                  data_o,
  output pd_mode_e                           mode_o
);
  localparam int WORD_W = DATA_W + 4;

  ld_sel_e ld;
  logic    ch_sel;
  logic    pd_frame;
  logic    addr;

  assign ld       = ld_sel_e'(word_i[WORD_W-1:WORD_W-2]);
  assign ch_sel   = word_i[WORD_W-3];
  assign pd_frame = word_i[WORD_W-4];
  assign data_o   = word_i[DATA_W-1:0];
  assign mode_o   = pd_mode_e'(word_i[DATA_W-1:DATA_W-2]);

  always_comb begin
    addr = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      ctl_o[c] = '0;
      addr     = (ld == LD_ALL) || (ch_sel == c[0]);
      if (apply_i) begin
        if (pd_frame) begin
          ctl_o[c].pd_we = addr;
        end else begin
          unique case (ld)
            LD_IN:   ctl_o[c].in_we = addr;
            LD_OUT:  ctl_o[c].out_we = addr;
            LD_XFER: begin
              ctl_o[c].in_we = addr;
              ctl_o[c].xfer  = 1'b1;
            end
            LD_ALL: begin
              ctl_o[c].in_we  = 1'b1;
              ctl_o[c].out_we = 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ch_ctl_t           ctl_i,
  input  logic [DATA_W-1:0] data_i,
  input  pd_mode_e          mode_i,
  output logic [DATA_W-1:0] code_o,
  output pd_mode_e          pd_o
);
  logic [DATA_W-1:0] in_q;
  logic [DATA_W-1:0] out_q;
  pd_mode_e          pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
      pd_q  <= PD_OFF;
    end else begin
      if (ctl_i.in_we) in_q <= data_i;
      if (ctl_i.out_we)    out_q <= data_i;
      else if (ctl_i.xfer) out_q <= ctl_i.in_we ? data_i : in_q;
      if (ctl_i.pd_we) pd_q <= mode_i;
    end
  end

  assign code_o = out_q;
  assign pd_o   = pd_q;
endmodule

// File: rtl/dac_cmd_bank.sv
module dac_cmd_bank
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              frame_edge_i,
  input  logic [DATA_W+3:0] word_i,
  output logic [DATA_W-1:0] code_a_o,
  output logic [DATA_W-1:0] code_b_o,
  output logic [1:0]        pd_a_o,
  output logic [1:0]        pd_b_o
);
  logic                  apply;
  ch_ctl_t [NUM_CH-1:0]  ctl;
  logic [DATA_W-1:0]     data;
  pd_mode_e              mode;
  logic [DATA_W-1:0]     code_w [NUM_CH];
  pd_mode_e              pd_w   [NUM_CH];

  dac_clr_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strobe_i     (strobe_i),
    .frame_edge_i (frame_edge_i),
    .apply_o      (apply)
  );

  dac_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .apply_i (apply),
    .word_i  (word_i),
    .ctl_o   (ctl),
    .data_o  (data),
    .mode_o  (mode)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dac_chan_regs #(.DATA_W(DATA_W)) u_regs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctl_i  (ctl[c]),
      .data_i (data),
      .mode_i (mode),
      .code_o (code_w[c]),
      .pd_o   (pd_w[c])
    );
  end

  assign code_a_o = code_w[0];
  assign code_b_o = code_w[1];
  assign pd_a_o   = pd_w[0];
  assign pd_b_o   = pd_w[1];
endmodule

// File: rtl/dac_cmd_bank_chk.sv
module dac_cmd_bank_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic              frame_edge_i,
  input logic [DATA_W+3:0] word_i,
  input logic [DATA_W-1:0] code_a_o,
  input logic [DATA_W-1:0] code_b_o,
  input logic [1:0]        pd_a_o,
  input logic [1:0]        pd_b_o
);
  localparam int WORD_W = DATA_W + 4;

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           seen_q <= 1'b0;
    else if (frame_edge_i) seen_q <= 1'b1;
  end

  logic       go;
  logic [1:0] ld;
  logic       chb;
  logic       pdf;
  assign go  = strobe_i && (frame_edge_i || seen_q);
  assign ld  = word_i[WORD_W-1:WORD_W-2];
  assign chb = word_i[WORD_W-3];
  assign pdf = word_i[WORD_W-4];

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go |=> $stable(code_a_o) && $stable(code_b_o) && $stable(pd_a_o) && $stable(pd_b_o)); // R8 R9

  AST_INPUT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !pdf && ld == 2'b00 |=> $stable(code_a_o) && $stable(code_b_o)); // R3

  AST_DIRECT_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !pdf && ld == 2'b01 && !chb |=> code_a_o == $past(word_i[DATA_W-1:0]) && $stable(code_b_o)); // R4

  AST_DIRECT_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !pdf && ld == 2'b01 && chb |=> code_b_o == $past(word_i[DATA_W-1:0]) && $stable(code_a_o)); // R4

  AST_BROADCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !pdf && ld == 2'b11 |=> code_a_o == $past(word_i[DATA_W-1:0]) && code_b_o == $past(word_i[DATA_W-1:0])); // R6

  AST_PD_KEEPS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && pdf |=> $stable(code_a_o) && $stable(code_b_o)); // R7

  AST_PD_MODE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && pdf && (ld == 2'b11 || !chb) |=> pd_a_o == $past(word_i[DATA_W-1:DATA_W-2])); // R7

  AST_PD_MODE_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && pdf && (ld == 2'b11 || chb) |=> pd_b_o == $past(word_i[DATA_W-1:DATA_W-2])); // R7
endmodule

bind dac_cmd_bank dac_cmd_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .strobe_i     (strobe_i),
  .frame_edge_i (frame_edge_i),
  .word_i       (word_i),
  .code_a_o     (code_a_o),
  .code_b_o     (code_b_o),
  .pd_a_o       (pd_a_o),
  .pd_b_o       (pd_b_o)
);

// File: tb/dac_cmd_bank_test.sv
`timescale 1ns/1ps
module dac_cmd_bank_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic        frame_edge_i = 1'b0;
  logic [15:0] word_i = '0;
  logic [11:0] code_a_o, code_b_o;
  logic [1:0]  pd_a_o, pd_b_o;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  // reference state
  logic [11:0] in_m  [2];
  logic [11:0] out_m [2];
  logic [1:0]  pd_m  [2];
  bit          armed_m;

  always #2.5 clk_i = ~clk_i;

  dac_cmd_bank uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strobe_i     (strobe_i),
    .frame_edge_i (frame_edge_i),
    .word_i       (word_i),
    .code_a_o     (code_a_o),
    .code_b_o     (code_b_o),
    .pd_a_o       (pd_a_o),
    .pd_b_o       (pd_b_o)
  );

  function automatic logic [15:0] mk(input int ld, input int ch, input int pd, input int d);
    return {ld[1:0], ch[0], pd[0], d[11:0]};
  endfunction

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      in_m[c] = '0; out_m[c] = '0; pd_m[c] = '0;
    end
    armed_m = 0;
  endtask

  task automatic model_apply(input logic [15:0] w);
    int ld = int'(w[15:14]);
    for (int c = 0; c < 2; c++) begin
      bit a = (ld == 3) || (int'(w[13]) == c);
      if (w[12]) begin
        if (a) pd_m[c] = w[11:10];
      end else if (ld == 0 || ld == 2) begin
        if (a) in_m[c] = w[11:0];
      end else if (ld == 1) begin
        if (a) out_m[c] = w[11:0];
      end else begin
        in_m[c] = w[11:0]; out_m[c] = w[11:0];
      end
    end
    if (!w[12] && ld == 2)
      for (int c = 0; c < 2; c++) out_m[c] = in_m[c];
  endtask

  task automatic compare();
    vectors++;
    if (code_a_o !== out_m[0] || code_b_o !== out_m[1] ||
        pd_a_o !== pd_m[0] || pd_b_o !== pd_m[1]) begin
      miscompares++;
      $display("FAIL %s: got A=%h/%b B=%h/%b expected A=%h/%b B=%h/%b", cur_req,
               code_a_o, pd_a_o, code_b_o, pd_b_o, out_m[0], pd_m[0], out_m[1], pd_m[1]);
    end
  endtask

  // compare last cycle, then drive next cycle's inputs and predict
  task automatic step(input logic [15:0] w, input bit stb, input bit fe);
    @(negedge clk_i);
    compare();
    word_i = w; strobe_i = stb; frame_edge_i = fe;
    if (stb && (fe || armed_m)) model_apply(w);
    if (fe) armed_m = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(16'h0000, 0, 0);
  endtask

  task automatic frame(input logic [15:0] w);
    step(w, 1, 1);
    idle(1);
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk_i);
    cur_req = "R1"; compare();
    rst_ni = 1'b1;
    idle(2);

    // R9: strobe before any frame edge is dropped; first edge applies
    cur_req = "R9";
    step(mk(1, 0, 0, 12'h123), 1, 0);
    idle(2);
    step(mk(1, 0, 0, 12'h456), 1, 1);
    idle(1);

    // R4 / R2: direct write to B
    cur_req = "R4"; frame(mk(1, 1, 0, 12'h789));
    // R3: staging write only
    cur_req = "R3"; frame(mk(0, 0, 0, 12'hAAA));
    // R4: direct write to A must not touch staging A
    cur_req = "R4"; frame(mk(1, 0, 0, 12'h111));
    // R5: transfer; A gets staged AAA, B gets new value
    cur_req = "R5"; frame(mk(2, 1, 0, 12'h222));
    cur_req = "R5"; frame(mk(2, 0, 0, 12'h000));
    // R6: broadcast, bit 13 ignored, full scale
    cur_req = "R6"; frame(mk(3, 1, 0, 12'hFFF));
    cur_req = "R6"; frame(mk(3, 0, 0, 12'h000));
    cur_req = "R6"; frame(mk(3, 0, 0, 12'h5A5));
    // R7: power-down modes
    cur_req = "R7"; frame(mk(0, 0, 1, 12'h400));
    cur_req = "R7"; frame(mk(1, 1, 1, 12'hC00));
    cur_req = "R7"; frame(mk(3, 0, 1, 12'h800));
    cur_req = "R7"; frame(mk(2, 1, 1, 12'h3FF));
    // R7: staging kept through power-down; transfer shows 5A5
    cur_req = "R7"; frame(mk(0, 1, 0, 12'h0C3));
    cur_req = "R7"; frame(mk(2, 0, 1, 12'hFFF));
    cur_req = "R7"; frame(mk(1, 0, 1, 12'h000));
    cur_req = "R5"; frame(mk(2, 1, 0, 12'h0C3));
    // R8: frame edge alone and idle words change nothing
    cur_req = "R8";
    step(mk(3, 0, 0, 12'hABC), 0, 1);
    step(mk(1, 1, 0, 12'hDEF), 0, 0);
    idle(2);
    // R8: back-to-back strobes, armed
    step(mk(1, 0, 0, 12'h010), 1, 0);
    step(mk(1, 1, 0, 12'h020), 1, 0);
    idle(1);

    // R10: asynchronous clear mid-cycle
    cur_req = "R10";
    @(negedge clk_i);
    compare();
    #1 rst_ni = 1'b0;
    #0.5;
    model_clear();
    compare();
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R9 again after clear
    cur_req = "R9";
    step(mk(3, 0, 0, 12'h777), 1, 0);
    idle(1);
    step(mk(3, 0, 0, 12'h321), 1, 1);
    idle(2);
    cur_req = "R9";
    step(mk(1, 1, 0, 12'h654), 1, 0);
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule